// File: doc/BRIEF.md
# Dual-Class Priority Interrupt Arbiter

This block picks one winning interrupt line for each of two service classes, a normal class and a fast class. It does this across a parameterised set of request lines, by default three banks of 32. Each line comes with a latched request bit, a mask bit, a class bit and a priority number. Those vectors come from capture and register logic outside this block. The winner for each class is computed combinationally, every cycle, over all lines.

Each class has an agreement flag. While the flag is set, the first cycle that finds a candidate, with the global enable high, arms the class output. On the next clock edge the output rises, the winning line's vector number is latched, and the flag clears. The output and vector then hold, whatever new requests arrive, until software pulses the re-arm strobe for that class. Both the re-arm strobe and the global enable are plain level or pulse pins. The block has no streaming data path, so it needs no valid/ready handshake and has no back-pressure: every input is sampled on every clock edge.

Top module: `pirq_arbiter`

## Requirements
- R1: A line is a candidate for a class only when its request bit is 1, its mask bit is 0 (1 means masked), and its class bit matches the class (1 = fast class, 0 = normal class).
- R2: Among candidates of one class, the line with the smallest priority number wins (0 is the most urgent).
- R3: When several candidates share the smallest priority number, the one with the largest line index wins.
- R4: The latched vector of a class equals 32 × bank + bit position, which is the line's global index.
- R5: When a class's flag is set, a candidate exists and the global enable is 1, the class output is 1 after the next clock edge. At that same edge the vector latches the winner and the flag clears.
- R6: Once a class output is 1, it stays 1 and its vector stays unchanged until that class is re-armed. This holds even when more urgent requests arrive.
- R7: A re-arm pulse (bit 0 for the normal class, bit 1 for the fast class) sets that class's flag and is evaluated in the same cycle. If a candidate exists and the global enable is 1, the output is 1 after the edge, carrying the new winner's vector. Otherwise the output is 0 after the edge.
- R8: While there is no candidate, or the global enable is 0, the output stays 0 and the flag stays set. A later candidate then fires without any re-arm.
- R9: After reset both outputs are 0, both vectors are 0 and both flags are set.
- R10: The two classes are independent: a re-arm, a candidate or a firing in one class does not change the other class's output or vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NLINE | Latched request per line |
| mask_i | input | NLINE | Per-line mask, 1 blocks the line |
| fast_i | input | NLINE | Per-line class, 1 = fast, 0 = normal |
| prio_i | input | NLINE*PRIO_W | Priority number per line, line i at bits [i*PRIO_W +: PRIO_W] |
| glob_en_i | input | 1 | Global enable, 0 blocks both classes |
| rearm_i | input | 2 | Re-arm strobe, bit 0 normal, bit 1 fast |
| norm_irq_o | output | 1 | Normal-class interrupt output |
| fast_irq_o | output | 1 | Fast-class interrupt output |
| norm_vec_o | output | VEC_W | Latched normal-class vector |
| fast_vec_o | output | VEC_W | Latched fast-class vector |

## Verification
The assertions check, on every cycle, the following sequential properties:
- the selected index is always a real candidate;
- an asserted output and its vector hold until re-arm;
- an output only rises from an armed state;
- the flag stays set while nothing can fire.

Whether the chosen line is actually the most urgent, and whether ties go to the highest index, can only be shown by the bench. It compares the latched vectors against its own reference winner under directed tie and cross-bank cases and under random request, mask, class and priority patterns. The same applies to the re-arm ordering and to the independence of the two classes.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned LINES_PER_BANK = 32;
  localparam int unsigned NUM_CLASSES    = 2;

  typedef enum logic {
    CLS_NORM = 1'b0,
    CLS_FAST = 1'b1
  } irq_cls_e;
endpackage

// File: rtl/pirq_filter.sv
module pirq_filter #(
  parameter int unsigned NLINE = 96,
  parameter pirq_pkg::irq_cls_e MATCH = pirq_pkg::CLS_NORM
) (
  input  logic [NLINE-1:0] req_i,
  input  logic [NLINE-1:0] mask_i,
  input  logic [NLINE-1:0] fast_i,
  output logic [NLINE-1:0] cand_o,
  output logic             any_o
);
  logic [NLINE-1:0] cls_sel;

  generate
    if (MATCH == pirq_pkg::CLS_FAST) begin : g_fast
      assign cls_sel = fast_i;
    end else begin : g_norm
      assign cls_sel = ~fast_i;
    end
  endgenerate

  assign cand_o = req_i & ~mask_i & cls_sel;
  assign any_o  = |cand_o;
endmodule

// File: rtl/pirq_pick.sv
module pirq_pick #(
  parameter int unsigned NLINE  = 96,
  parameter int unsigned PRIO_W = 6,
  localparam int unsigned VEC_W = $clog2(NLINE)
) (
  input  logic [NLINE-1:0]        cand_i,
  input  logic [NLINE*PRIO_W-1:0] prio_i,
  output logic [VEC_W-1:0]        win_o
);
  logic [PRIO_W-1:0] best;

  // ascending scan, "<=" lets a later (higher) index take a tie
  always_comb begin
    best  = '1;
    win_o = '0;
    for (int i = 0; i < NLINE; i++) begin
      if (cand_i[i] && (prio_i[i*PRIO_W +: PRIO_W] <= best)) begin
        best  = prio_i[i*PRIO_W +: PRIO_W];
        win_o = VEC_W'(i);
      end
    end
  end
endmodule

// File: rtl/pirq_agree.sv
module pirq_agree #(
  parameter int unsigned VEC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_i,
  input  logic             glob_en_i,
  input  logic             rearm_i,
  input  logic [VEC_W-1:0] win_i,
  output logic             out_o,
  output logic [VEC_W-1:0] vec_o
);
  logic arm_q;
  logic out_q;
  logic [VEC_W-1:0] vec_q;
  logic fire;

  assign fire = (arm_q | rearm_i) & any_i & glob_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b1;
      out_q <= 1'b0;
      vec_q <= '0;
    end else if (fire) begin
      arm_q <= 1'b0;
      out_q <= 1'b1;
      vec_q <= win_i;
    end else if (rearm_i) begin
      arm_q <= 1'b1;
      out_q <= 1'b0;
    end
  end

  assign out_o = out_q;
  assign vec_o = vec_q;

  // R6
  hold_until_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_q && !rearm_i |=> out_q && $stable(vec_q));

  // R5
  rise_from_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> ($past(arm_q) || $past(rearm_i)));

  // R8
  idle_keeps_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q && !(any_i && glob_en_i) |=> arm_q && !out_q);

  // R7
  rearm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i && !(any_i && glob_en_i) |=> arm_q && !out_q);
endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter #(
  parameter int unsigned NBANK  = 3,
  parameter int unsigned PRIO_W = 6,
  localparam int unsigned NLINE = NBANK * pirq_pkg::LINES_PER_BANK,
  localparam int unsigned VEC_W = $clog2(NLINE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLINE-1:0]        req_i,
  input  logic [NLINE-1:0]        mask_i,
  input  logic [NLINE-1:0]        fast_i,
  input  logic [NLINE*PRIO_W-1:0] prio_i,
  input  logic                    glob_en_i,
  input  logic [1:0]              rearm_i,
  output logic                    norm_irq_o,
  output logic                    fast_irq_o,
  output logic [VEC_W-1:0]        norm_vec_o,
  output logic [VEC_W-1:0]        fast_vec_o
);
  logic [NLINE-1:0] cand [pirq_pkg::NUM_CLASSES];
  logic             any  [pirq_pkg::NUM_CLASSES];
  logic [VEC_W-1:0] win  [pirq_pkg::NUM_CLASSES];
  logic             outc [pirq_pkg::NUM_CLASSES];
  logic [VEC_W-1:0] vecc [pirq_pkg::NUM_CLASSES];

  generate
    for (genvar c = 0; c < pirq_pkg::NUM_CLASSES; c++) begin : g_cls
      localparam pirq_pkg::irq_cls_e CLS = (c == 1) ? pirq_pkg::CLS_FAST : pirq_pkg::CLS_NORM;

      pirq_filter #(.NLINE(NLINE), .MATCH(CLS)) u_filt (
        .req_i  (req_i),
        .mask_i (mask_i),
        .fast_i (fast_i),
        .cand_o (cand[c]),
        .any_o  (any[c])
      );

      pirq_pick #(.NLINE(NLINE), .PRIO_W(PRIO_W)) u_pick (
        .cand_i (cand[c]),
        .prio_i (prio_i),
        .win_o  (win[c])
      );

      pirq_agree #(.VEC_W(VEC_W)) u_agree (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_i     (any[c]),
        .glob_en_i (glob_en_i),
        .rearm_i   (rearm_i[c]),
        .win_i     (win[c]),
        .out_o     (outc[c]),
        .vec_o     (vecc[c])
      );

      // R2
      win_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any[c] |-> cand[c][win[c]]);
    end
  endgenerate

  assign norm_irq_o = outc[0];
  assign fast_irq_o = outc[1];
  assign norm_vec_o = vecc[0];
  assign fast_vec_o = vecc[1];

  // R1
  class_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand[0] & cand[1]) == '0);
endmodule

// File: tb/pirq_arbiter_test.sv
module pirq_arbiter_test;
  localparam int N  = 96;
  localparam int PW = 6;
  localparam int VW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, mask = '1, fast = '0;
  logic [N*PW-1:0] prio = '0;
  logic glob_en = 1'b1;
  logic [1:0] rearm = 2'b00;
  logic norm_irq, fast_irq;
  logic [VW-1:0] norm_vec, fast_vec;

  int n_chk = 0, n_fail = 0;
  logic m_arm [2];
  logic m_out [2];
  int   m_vec [2];

  always #4 clk = ~clk;

  pirq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .fast_i(fast),
    .prio_i(prio), .glob_en_i(glob_en), .rearm_i(rearm),
    .norm_irq_o(norm_irq), .fast_irq_o(fast_irq),
    .norm_vec_o(norm_vec), .fast_vec_o(fast_vec)
  );

  // reference: scan from the top, keep the first strictly better entry
  function automatic int ref_win(input int c, output bit found);
    int best_p = 1 << PW;
    int w = 0;
    found = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && !mask[i] && (fast[i] == c[0])) begin
        if (int'(prio[i*PW +: PW]) < best_p) begin
          best_p = int'(prio[i*PW +: PW]);
          w = i;
          found = 1;
        end
      end
    end
    return w;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check({tag, " norm_irq"}, int'(norm_irq), int'(m_out[0]));
    check({tag, " fast_irq"}, int'(fast_irq), int'(m_out[1]));
    check({tag, " norm_vec"}, int'(norm_vec), m_vec[0]);
    check({tag, " fast_vec"}, int'(fast_vec), m_vec[1]);
  endtask

  // inputs are set at a falling edge before calling
  task automatic step(input string tag);
    for (int c = 0; c < 2; c++) begin
      bit f;
      int w;
      w = ref_win(c, f);
      if ((m_arm[c] || rearm[c]) && f && glob_en) begin
        m_arm[c] = 0; m_out[c] = 1; m_vec[c] = w;
      end else if (rearm[c]) begin
        m_arm[c] = 1; m_out[c] = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    rearm = 2'b00;
    compare(tag);
  endtask

  task automatic set_prio(input int line, input int p);
    prio[line*PW +: PW] = PW'(p);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_arm[c] = 1; m_out[c] = 0; m_vec[c] = 0;
    end
    for (int i = 0; i < N; i++) set_prio(i, 10);
    repeat (3) @(negedge clk);
    compare("R9 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R9 after release");

    // R1: request present but masked, then unmasked as fast
    req[3] = 1'b1;
    step("R1 masked");
    mask[3] = 1'b0; fast[3] = 1'b1;
    step("R1 R5 fast fire");
    // R8: global disable blocks the normal class
    glob_en = 1'b0; req[40] = 1'b1; mask[40] = 1'b0;
    step("R8 disabled");
    step("R8 disabled again");
    glob_en = 1'b1;
    step("R8 R4 fire without rearm");
    // R6: more urgent line in bank 2 does not disturb held vector
    req[70] = 1'b1; mask[70] = 1'b0; set_prio(70, 0);
    step("R6 hold");
    rearm = 2'b01;
    step("R7 R4 R2 R10 rearm normal");
    // R3: tie among lines 10, 20, 90
    req = '0; mask = '1; fast = '0;
    foreach (req[i]) if (i == 10 || i == 20 || i == 90) begin
      req[i] = 1'b1; mask[i] = 1'b0; set_prio(i, 1);
    end
    set_prio(5, 1); req[5] = 1'b1; mask[5] = 1'b0;
    rearm = 2'b01;
    step("R3 tie");
    // R7 R10: re-arm both with no fast candidate
    rearm = 2'b11;
    step("R7 R10 both rearm");
    mask[3] = 1'b0; req[3] = 1'b1; fast[3] = 1'b1;
    step("R8 R10 fast later");

    // random phase
    void'($urandom(32'h5eed_1234));
    for (int it = 0; it < 3000; it++) begin
      for (int i = 0; i < N; i++) begin
        req[i]  = ($urandom % 4) == 0;
        mask[i] = ($urandom % 3) == 0;
        fast[i] = ($urandom % 2) == 0;
        set_prio(i, int'($urandom % 4));
      end
      glob_en = ($urandom % 8) != 0;
      rearm = 2'($urandom % 4);
      step("R1 R2 R3 R5 R7 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule